// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter. A start command launches a conversion with three phases. First comes a sample-and-hold phase of programmable length. Ten bit trials follow, resolved from the most significant bit down. A single transfer cycle ends the conversion, loads the result register and raises a sticky interrupt. The analog comparator and the DAC are outside the block. The block drives a trial code to the DAC and reads back one comparator bit.

All logic runs on the I/O clock. The conversion clock is a one-cycle enable pulse from a counter, with a selectable divide ratio of 1, 2, 3, 4, 8 or 16. In continuous mode the sequencer moves from the transfer cycle straight into a new sample-and-hold phase. It stops after the first transfer cycle that sees the mode flag low.

Top module: `sar_adc_seq`

## Requirements
- R1: The conversion clock period is the I/O clock period times a ratio picked by `div_sel_i`: code 0→1, 1→2, 2→3, 3→4, 4→8, and codes 5, 6, 7→16. The enable counter restarts at zero on each start.
- R2: `sh_o` is high for N conversion clocks at the beginning of each conversion. N is the value of `sh_cyc_i`, and a value of 0 gives N=1. During that phase `dac_o` is zero.
- R3: `busy_o` rises on the cycle after an accepted start and stays high for exactly (N+11)·ratio I/O clocks.
- R4: The first trial code after sample-and-hold is 0x200, with only bit 9 set. Each trial sets the bit under test, keeps the bits already decided and leaves all lower bits zero.
- R5: A tested bit stays 1 when `cmp_i` is 1 at the end of its conversion clock and is cleared otherwise. If the comparator reports (input ≥ DAC code), the result equals the input code.
- R6: `result_o` changes only at the end of the transfer cycle. At all other times it holds its value.
- R7: `irq_o` is set at the end of the transfer cycle and stays high until a cycle with `irq_clr_i`=1.
- R8: A start while busy has no effect. The divide select and the S/H length are captured at the accepted start and do not change during the conversion.
- R9: When `cont_i` is high at the end of the transfer cycle, a new sample-and-hold phase begins on the next cycle and `busy_o` stays high. When it is low, the sequencer goes idle.
- R10: After reset, `busy_o`, `sh_o`, `irq_o`, `dac_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, honoured only when idle |
| div_sel_i | input | 3 | Conversion clock divide select |
| sh_cyc_i | input | SH_W (3) | Sample-and-hold length in conversion clocks (0 acts as 1) |
| cont_i | input | 1 | Continuous conversion enable |
| cmp_i | input | 1 | Comparator: 1 when input ≥ DAC output |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt |
| dac_o | output | RES_W (10) | Trial code to the DAC |
| sh_o | output | 1 | Sample-and-hold strobe |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | RES_W (10) | Last completed result |
| irq_o | output | 1 | Sticky conversion-done interrupt |

## Verification
The assertions check the following on every cycle:
- the enable counter stays in range and enable pulses never arrive back to back;
- the trial code has a legal shape and is zero during sample-and-hold;
- each decided bit matches the comparator value from the previous cycle;
- the result register holds between transfers and the interrupt stays set until cleared;
- the captured settings stay put when a start arrives during a busy conversion.

Some behaviours involve whole conversions, and only the bench scenarios can show them:
- the total busy length and the S/H length for every divide code and several S/H settings;
- the correct final code for boundary and mid-scale inputs;
- back-to-back continuous conversions with a changing input, and the stop after the mode flag is dropped.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  localparam int unsigned DIV_SEL_W = 3;
  localparam int unsigned MAX_RATIO = 16;
  localparam int unsigned RATIO_W   = $clog2(MAX_RATIO) + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SH,
    ST_BIT,
    ST_XFER
  } seq_state_e;

  function automatic logic [RATIO_W-1:0] div_ratio(input logic [DIV_SEL_W-1:0] sel);
    logic [RATIO_W-1:0] r;
    case (sel)
      3'd0:    r = RATIO_W'(1);
      3'd1:    r = RATIO_W'(2);
      3'd2:    r = RATIO_W'(3);
      3'd3:    r = RATIO_W'(4);
      3'd4:    r = RATIO_W'(8);
      default: r = RATIO_W'(MAX_RATIO);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sar_clk_en.sv
module sar_clk_en
  import sar_seq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [DIV_SEL_W-1:0] sel_i,
  output logic                 cke_o
);

  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] cnt_q;

  assign ratio = div_ratio(sel_i);
  assign cke_o = run_i && (cnt_q == ratio - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || cke_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < ratio)); // R1

  AST_CKE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && ratio != RATIO_W'(1)) |=> !cke_o); // R1

  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  parameter int unsigned SH_W  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic [SH_W-1:0]      sh_cyc_i,
  input  logic                 cont_i,
  input  logic                 cmp_i,
  input  logic                 cke_i,
  output logic [DIV_SEL_W-1:0] div_sel_o,
  output logic                 busy_o,
  output logic                 sh_o,
  output logic [RES_W-1:0]     dac_o,
  output logic                 xfer_o
);

  localparam int unsigned IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(RES_W - 1);

  seq_state_e             state_q;
  logic [SH_W-1:0]        sh_cnt_q;
  logic [SH_W-1:0]        sh_len_q;
  logic [DIV_SEL_W-1:0]   div_sel_q;
  logic [IDX_W-1:0]       idx_q;
  logic [RES_W-1:0]       code_q;
  logic                   sh_last;
  logic [RES_W-1:0]       cur_bit;
  logic [RES_W-1:0]       low_mask;

  assign sh_last  = (sh_cnt_q == sh_len_q - 1'b1);
  assign cur_bit  = {{(RES_W-1){1'b0}}, 1'b1} << idx_q;
  assign low_mask = cur_bit - 1'b1;

  assign busy_o    = (state_q != ST_IDLE);
  assign sh_o      = (state_q == ST_SH);
  assign xfer_o    = (state_q == ST_XFER) && cke_i;
  assign dac_o     = code_q;
  assign div_sel_o = div_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sh_cnt_q  <= '0;
      sh_len_q  <= SH_W'(1);
      div_sel_q <= '0;
      idx_q     <= '0;
      code_q    <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q   <= ST_SH;
        sh_cnt_q  <= '0;
        sh_len_q  <= (sh_cyc_i == '0) ? SH_W'(1) : sh_cyc_i;
        div_sel_q <= div_sel_i;
        code_q    <= '0;
      end
    end else if (cke_i) begin
      unique case (state_q)
        ST_SH: begin
          if (sh_last) begin
            state_q <= ST_BIT;
            idx_q   <= IDX_TOP;
            code_q  <= {1'b1, {(RES_W-1){1'b0}}};
          end else begin
            sh_cnt_q <= sh_cnt_q + 1'b1;
          end
        end
        ST_BIT: begin
          code_q[idx_q] <= cmp_i;
          if (idx_q == '0) begin
            state_q <= ST_XFER;
          end else begin
            code_q[idx_q - 1'b1] <= 1'b1;
            idx_q                <= idx_q - 1'b1;
          end
        end
        ST_XFER: begin
          if (cont_i) begin
            state_q  <= ST_SH;
            sh_cnt_q <= '0;
            code_q   <= '0;
          end else begin
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(div_sel_q) && $stable(sh_len_q))); // R8

  AST_SH_ZERO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_o |-> (dac_o == '0)); // R2

  AST_TRIAL_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BIT) |-> (((dac_o & cur_bit) != '0) && ((dac_o & low_mask) == '0))); // R4

  AST_MSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_o && cke_i && sh_last) |=> (dac_o == {1'b1, {(RES_W-1){1'b0}}})); // R4

  AST_BIT_DECIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_BIT) && cke_i) |=> (((dac_o & $past(cur_bit)) != '0) == $past(cmp_i))); // R5

  AST_CONT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && cont_i) |=> (sh_o && busy_o)); // R9

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !cont_i) |=> !busy_o); // R9

endmodule

// File: rtl/sar_result_irq.sv
module sar_result_irq #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_i,
  input  logic [RES_W-1:0] code_i,
  input  logic             irq_clr_i,
  output logic [RES_W-1:0] result_o,
  output logic             irq_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      if (xfer_i) result_o <= code_i;
      if (xfer_i)         irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(result_o)); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o); // R7

  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> irq_o); // R7

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  parameter int unsigned SH_W  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic [SH_W-1:0]      sh_cyc_i,
  input  logic                 cont_i,
  input  logic                 cmp_i,
  input  logic                 irq_clr_i,
  output logic [RES_W-1:0]     dac_o,
  output logic                 sh_o,
  output logic                 busy_o,
  output logic [RES_W-1:0]     result_o,
  output logic                 irq_o
);

  logic                 cke;
  logic                 xfer;
  logic [DIV_SEL_W-1:0] div_sel_q;

  sar_clk_en u_clk_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .sel_i  (div_sel_q),
    .cke_o  (cke)
  );

  sar_seq_ctrl #(
    .RES_W (RES_W),
    .SH_W  (SH_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .div_sel_i (div_sel_i),
    .sh_cyc_i  (sh_cyc_i),
    .cont_i    (cont_i),
    .cmp_i     (cmp_i),
    .cke_i     (cke),
    .div_sel_o (div_sel_q),
    .busy_o    (busy_o),
    .sh_o      (sh_o),
    .dac_o     (dac_o),
    .xfer_o    (xfer)
  );

  sar_result_irq #(
    .RES_W (RES_W)
  ) u_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xfer_i    (xfer),
    .code_i    (dac_o),
    .irq_clr_i (irq_clr_i),
    .result_o  (result_o),
    .irq_o     (irq_o)
  );

endmodule

// File: tb/tb_sar_adc_seq.sv
`timescale 1ns/1ps
module tb_sar_adc_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] div_sel = '0;
  logic [2:0] sh_cyc = 3'd1;
  logic       cont = 1'b0;
  logic       irq_clr = 1'b0;
  logic [9:0] vin = '0;
  logic [9:0] dac;
  logic       sh;
  logic       busy;
  logic [9:0] result;
  logic       irq;
  logic       cmp;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  assign cmp = (vin >= dac);

  sar_adc_seq dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .div_sel_i (div_sel),
    .sh_cyc_i  (sh_cyc),
    .cont_i    (cont),
    .cmp_i     (cmp),
    .irq_clr_i (irq_clr),
    .dac_o     (dac),
    .sh_o      (sh),
    .busy_o    (busy),
    .result_o  (result),
    .irq_o     (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input int sel);
    case (sel)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [9:0] vin_of(input int i);
    case (i)
      0: return 10'd0;
      1: return 10'd1023;
      2: return 10'd512;
      3: return 10'd511;
      4: return 10'd341;
      default: return 10'd682;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // One conversion; optionally pokes start mid-run with other settings (R8)
  task automatic run_conv(input int sel, input int shc, input logic [9:0] v, input bit poke);
    int rr, nsh, busy_n, sh_n, res_moves, irq_early;
    logic [9:0] first_trial, prev;
    bit got_first;
    rr = ratio_of(sel);
    nsh = (shc == 0) ? 1 : shc;
    vin = v;
    div_sel = 3'(sel);
    sh_cyc = 3'(shc);
    prev = result;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    busy_n = 0; sh_n = 0; res_moves = 0; irq_early = 0;
    got_first = 1'b0; first_trial = '0;
    while (busy && busy_n < 2000) begin
      busy_n++;
      if (sh) sh_n++;
      if (!sh && !got_first) begin first_trial = dac; got_first = 1'b1; end
      if (result != prev) res_moves++;
      if (irq) irq_early++;
      if (poke && busy_n == 2) begin start = 1'b1; div_sel = 3'(sel ^ 1); sh_cyc = 3'd7; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(busy_n == (nsh + 11) * rr, poke ? "R8 busy length with start while busy" : "R3 busy length",
        busy_n, (nsh + 11) * rr);
    chk(sh_n == nsh * rr, "R2 sh length", sh_n, nsh * rr);
    chk(first_trial == 10'h200, "R4 first trial", first_trial, 10'h200);
    chk(result == v, "R5 result code", result, v);
    chk(res_moves == 0, "R6 result held while busy", res_moves, 0);
    chk(irq == 1'b1 && irq_early == 0, "R7 irq at transfer", irq, 1);
    @(negedge clk);
    chk(irq == 1'b1 && !busy, "R7 irq held without clear", irq, 1);
    irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk(irq == 1'b0, "R7 irq cleared", irq, 0);
  endtask

  initial begin
    int drops;
    repeat (3) @(negedge clk);
    chk(busy == 0 && sh == 0 && irq == 0, "R10 reset flags", {busy, sh, irq}, 0);
    chk(dac == '0 && result == '0, "R10 reset data", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep of divide codes, S/H settings and inputs (R1..R7)
    for (int s = 0; s < 8; s++) begin
      for (int h = 0; h < 5; h++) begin
        for (int k = 0; k < 6; k++) begin
          int shv;
          shv = (h == 0) ? 0 : (h == 1) ? 1 : (h == 2) ? 2 : (h == 3) ? 4 : 7;
          run_conv(s, shv, vin_of(k), (k == 0) && (h == 2)); // R1
        end
      end
    end

    // Continuous mode (R9)
    div_sel = 3'd1; sh_cyc = 3'd2; cont = 1'b1; vin = 10'd300;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!irq && cyc < 100000) @(negedge clk);
    chk(result == 10'd300, "R9 first continuous result", result, 300);
    chk(busy && sh, "R9 restart into sh", {busy, sh}, 3);
    vin = 10'd700;
    irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    cont = 1'b0;
    drops = 0;
    while (!irq && cyc < 100000) begin
      if (!busy) drops++;
      @(negedge clk);
    end
    chk(drops == 0, "R9 busy kept between conversions", drops, 0);
    chk(result == 10'd700, "R9 second continuous result", result, 700);
    chk(!busy, "R9 stop after transfer", busy, 0);
    repeat (40) @(negedge clk);
    chk(!busy && result == 10'd700, "R9 stays idle", busy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule